// File: doc/BRIEF.md
# Command-Driven SPI Master

This block is a single-channel SPI master behind a simple register read/write port. Software loads 32-bit words into a transmit queue and then writes one command word. The command selects transmit, receive or both, gives the number of bits minus one, and says whether chip select stays asserted once the command ends. The block derives the serial clock from a programmable divider and shifts data out and in using the configured clock polarity, clock phase and bit order. Received bits are packed into words in a receive queue. Software reads these words back.

Flags in the status register are sticky and are cleared by writing ones. Five of them can raise one interrupt line through an enable mask. Setting the continue flag lets a long frame be built from several commands without chip select dropping between them. A capture-delay option moves the MISO sample one core clock later, for links run at the fastest divider.

Top module: `spi_cmd_master`

## Requirements
- R1: After reset, the following reads hold. Configuration reads 0. Divider reads 4. Word count reads 0. Status reads 0x04: only the transmit-threshold bit is set, because an empty queue meets level 0. SCLK, chip select, MOSI and the interrupt are all low.
- R2: Register offsets are as follows: configuration 0x00, divider 0x04, command 0x08, status 0x0C, interrupt enable 0x10, thresholds 0x14, word count 0x18, transmit data 0x1C and receive data 0x20. The configuration bits are CPHA (0), CPOL (1), chip-select active-low (2), MOSI enable (4), MISO enable (5), LSB-first (10) and late capture (11). Writing all ones to configuration reads back 0xC37.
- R3: One SCLK period lasts as many core clocks as the divider value. A divider below 4 acts as 4. While no command runs, SCLK rests at the CPOL level.
- R4: The command word is decoded as follows. Bit 0 requests transmit and bit 1 requests receive. Bit 4 is the continue flag. Bits 31:16 hold the bit count minus one. A command with bits 1:0 both zero starts nothing.
- R5: Within a word, the first bit on the wire is the highest used bit. A final partial word of n bits is right-aligned. When LSB-first is set, each word goes out from bit 0 upward. Received words follow the same layout.
- R6: With CPHA=0, MOSI is valid before the leading SCLK edge and MISO is sampled on that edge. With CPHA=1, MOSI changes on the leading edge and is stable across the trailing edge.
- R7: Chip select asserts when a command starts. It is active high, or active low when configuration bit 2 is set. At the end of a command it is released, unless the continue flag was set.
- R8: Status bit 0 (pending) is high while a command runs. Status bit 1 (done) sets on the trailing SCLK edge of the last bit and clears when a one is written to it.
- R9: A command written while pending is high is ignored.
- R10: The transmit queue may be empty when a new word is needed during a transmit command. In that case zeros are shifted out and status bit 4 sets.
- R11: A received word that arrives while the receive queue is full is dropped, and status bit 5 sets.
- R12: Status bit 2 sets while the transmit count is at or below threshold bits 3:0. Status bit 3 sets when the receive count is nonzero and at or above threshold bits 7:4, or when the last word of a receive command is stored.
- R13: The interrupt output is the OR of status bits 1..5, each gated by enable bits 0..4 in that order.
- R14: When late capture is set, MISO is taken one core clock after the sampling SCLK edge rather than on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops the receive queue at 0x20) |
| reg_addr | input | 6 | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from reg_addr |
| irq | output | 1 | Interrupt request |
| sclk | output | 1 | Serial clock |
| cs_o | output | 1 | Chip select |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
The bench uses the default parameters: an 8-word queue in each direction and a divider floor of 4. With these values, the fastest SCLK rate and the late-capture timing are exercised directly. A 288-bit receive command, nine words, overruns the receive queue in about a thousand cycles. The shallow queue also makes the threshold levels and the underflow on a second transmit word reachable with a handful of register writes.

// File: rtl/spi_cmd_master.sv
module spi_cmd_master #(
  parameter int FIFO_DEPTH = 8,
  parameter int DIV_FLOOR  = 4,
  parameter int AW         = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [AW-1:0] reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          irq,
  output logic          sclk,
  output logic          cs_o,
  output logic          mosi,
  input  logic          miso
);
  localparam int PW = (FIFO_DEPTH > 1) ? $clog2(FIFO_DEPTH) : 1;
  localparam int CW = $clog2(FIFO_DEPTH + 1);
  localparam logic [AW-1:0] A_CFG  = AW'(6'h00);
  localparam logic [AW-1:0] A_DIV  = AW'(6'h04);
  localparam logic [AW-1:0] A_CMD  = AW'(6'h08);
  localparam logic [AW-1:0] A_STAT = AW'(6'h0C);
  localparam logic [AW-1:0] A_IEN  = AW'(6'h10);
  localparam logic [AW-1:0] A_THR  = AW'(6'h14);
  localparam logic [AW-1:0] A_CNT  = AW'(6'h18);
  localparam logic [AW-1:0] A_TXD  = AW'(6'h1C);
  localparam logic [AW-1:0] A_RXD  = AW'(6'h20);
  localparam logic [15:0]   DMIN   = 16'(DIV_FLOOR);

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(FIFO_DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  // configuration fields
  logic cpha, cpol, cs_low, tx_en, rx_en, lsb, late;
  logic [15:0] div_r;
  logic [4:0]  ien;
  logic [7:0]  thr;
  logic st_done, st_txth, st_rxth, st_uf, st_of;

  // engine state
  logic        busy, do_tx, do_rx, cont, cs_act, sph, mosi_h;
  logic [15:0] cnt;
  logic [16:0] left;
  logic [4:0]  widx, cap_pos;
  logic [5:0]  wbits;
  logic [31:0] txw, rxw, rx_next;
  logic        cap_pend, push_pend, push_last;

  // queues
  logic [31:0]   txm [FIFO_DEPTH];
  logic [31:0]   rxm [FIFO_DEPTH];
  logic [PW-1:0] tx_wp, tx_rp, rx_wp, rx_rp;
  logic [CW-1:0] tx_cnt, rx_cnt;

  wire wr_cfg  = reg_wr && reg_addr == A_CFG;
  wire wr_div  = reg_wr && reg_addr == A_DIV;
  wire wr_cmd  = reg_wr && reg_addr == A_CMD;
  wire wr_stat = reg_wr && reg_addr == A_STAT;
  wire wr_ien  = reg_wr && reg_addr == A_IEN;
  wire wr_thr  = reg_wr && reg_addr == A_THR;
  wire wr_txd  = reg_wr && reg_addr == A_TXD;
  wire rd_rxd  = reg_rd && reg_addr == A_RXD;

  wire [15:0] d_eff = (div_r < DMIN) ? DMIN : div_r;
  wire [15:0] hd    = d_eff >> 1;
  wire lead  = busy && cnt == hd - 16'd1;
  wire trail = busy && cnt == d_eff - 16'd1;

  wire [16:0] total    = {1'b0, reg_wdata[31:16]} + 17'd1;
  wire [16:0] left_m1  = left - 17'd1;
  wire        last_bit = left == 17'd1;
  wire        word_end = {1'b0, widx} == wbits - 6'd1;
  wire [4:0]  pos      = lsb ? widx : (wbits[4:0] - 5'd1 - widx);
  wire        start    = wr_cmd && !busy && (reg_wdata[1:0] != 2'b00);

  wire tx_empty = tx_cnt == '0;
  wire tx_full  = tx_cnt == CW'(FIFO_DEPTH);
  wire rx_full  = rx_cnt == CW'(FIFO_DEPTH);
  wire fetch    = (start && reg_wdata[0]) || (trail && do_tx && !last_bit && word_end);
  wire tx_pop   = fetch && !tx_empty;
  wire tx_push  = wr_txd && !tx_full;
  wire rx_push  = push_pend && !rx_full;
  wire rx_pop   = rd_rxd && rx_cnt != '0;

  wire samp_evt = busy && do_rx && (cpha ? trail : lead);
  wire ins      = (samp_evt && !late) || cap_pend;
  wire [4:0] ins_pos = cap_pend ? cap_pos : pos;

  always_comb begin
    rx_next = rxw;
    if (ins) rx_next[ins_pos] = miso & rx_en;
  end

  assign sclk = sph ^ cpol;
  assign cs_o = cs_act ^ cs_low;
  assign mosi = tx_en & (cpha ? mosi_h : (busy & do_tx & txw[pos]));
  assign irq  = |(ien & {st_of, st_uf, st_rxth, st_txth, st_done});

  // register file
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {cpha, cpol, cs_low, tx_en, rx_en, lsb, late} <= '0;
      div_r <= DMIN;
      ien   <= '0;
      thr   <= '0;
    end else begin
      if (wr_cfg) begin
        cpha <= reg_wdata[0];  cpol  <= reg_wdata[1];  cs_low <= reg_wdata[2];
        tx_en <= reg_wdata[4]; rx_en <= reg_wdata[5];
        lsb  <= reg_wdata[10]; late  <= reg_wdata[11];
      end
      if (wr_div) div_r <= reg_wdata[15:0];
      if (wr_ien) ien   <= reg_wdata[4:0];
      if (wr_thr) thr   <= reg_wdata[7:0];
    end
  end

  // status flags: set by events, cleared by writing ones
  wire [5:0] w1c = wr_stat ? reg_wdata[5:0] : 6'd0;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {st_done, st_txth, st_rxth, st_uf, st_of} <= '0;
    end else begin
      st_done <= (st_done & ~w1c[1]) | (trail & last_bit);
      st_txth <= (st_txth & ~w1c[2]) | (32'(tx_cnt) <= 32'(thr[3:0]));
      st_rxth <= (st_rxth & ~w1c[3]) | (rx_cnt != '0 && 32'(rx_cnt) >= 32'(thr[7:4]))
                 | (push_pend & push_last);
      st_uf   <= (st_uf & ~w1c[4]) | (fetch & tx_empty);
      st_of   <= (st_of & ~w1c[5]) | (push_pend & rx_full);
    end
  end

  // shift sequencer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {busy, do_tx, do_rx, cont, cs_act, sph, mosi_h} <= '0;
      cnt <= '0; left <= '0; widx <= '0; wbits <= '0;
    end else if (start) begin
      busy   <= 1'b1;
      do_tx  <= reg_wdata[0];
      do_rx  <= reg_wdata[1];
      cont   <= reg_wdata[4];
      cs_act <= 1'b1;
      sph    <= 1'b0;
      mosi_h <= 1'b0;
      cnt    <= '0;
      left   <= total;
      widx   <= '0;
      wbits  <= (total > 17'd32) ? 6'd32 : total[5:0];
    end else if (busy) begin
      cnt <= trail ? '0 : cnt + 16'd1;
      if (lead) begin
        sph    <= 1'b1;
        mosi_h <= do_tx & txw[pos];
      end
      if (trail) begin
        sph <= 1'b0;
        if (last_bit) begin
          busy   <= 1'b0;
          cs_act <= cont;
        end else begin
          left <= left_m1;
          if (word_end) begin
            widx  <= '0;
            wbits <= (left_m1 > 17'd32) ? 6'd32 : left_m1[5:0];
          end else begin
            widx <= widx + 5'd1;
          end
        end
      end
    end
  end

  // word staging
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txw <= '0; rxw <= '0; cap_pos <= '0;
      {cap_pend, push_pend, push_last} <= '0;
    end else begin
      if (fetch) txw <= tx_empty ? '0 : txm[tx_rp];
      cap_pend  <= samp_evt & late;
      if (samp_evt) cap_pos <= pos;
      push_pend <= busy & do_rx & trail & (word_end | last_bit);
      push_last <= busy & do_rx & trail & last_bit;
      if (push_pend) rxw <= '0;
      else if (ins)  rxw <= rx_next;
    end
  end

  // queues
  always_ff @(posedge clk) begin
    if (tx_push) txm[tx_wp] <= reg_wdata;
    if (rx_push) rxm[rx_wp] <= rx_next;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
    end else begin
      if (tx_push) tx_wp <= nxt(tx_wp);
      if (tx_pop)  tx_rp <= nxt(tx_rp);
      tx_cnt <= tx_cnt + CW'(tx_push) - CW'(tx_pop);
      if (rx_push) rx_wp <= nxt(rx_wp);
      if (rx_pop)  rx_rp <= nxt(rx_rp);
      rx_cnt <= rx_cnt + CW'(rx_push) - CW'(rx_pop);
    end
  end

  always_comb begin
    case (reg_addr)
      A_CFG:  reg_rdata = {20'd0, late, lsb, 4'd0, rx_en, tx_en, 1'b0, cs_low, cpol, cpha};
      A_DIV:  reg_rdata = {16'd0, div_r};
      A_STAT: reg_rdata = {26'd0, st_of, st_uf, st_rxth, st_txth, st_done, busy};
      A_IEN:  reg_rdata = {27'd0, ien};
      A_THR:  reg_rdata = {24'd0, thr};
      A_CNT:  reg_rdata = {24'd0, 4'(tx_cnt), 4'(rx_cnt)};
      A_RXD:  reg_rdata = (rx_cnt != '0) ? rxm[rx_rp] : 32'd0;
      default: reg_rdata = 32'd0;
    endcase
  end

  p_cs_active_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cs_o != cs_low));
  p_sclk_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (sclk == cpol));
  p_done_at_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_done) |-> $fell(busy));
  p_cmd_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_cmd && !trail) |=> (busy && $stable(left) && $stable(do_rx)));
  p_tx_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
    32'(tx_cnt) <= FIFO_DEPTH);
  p_rx_bound_r11: assert property (@(posedge clk) disable iff (!rst_n)
    32'(rx_cnt) <= FIFO_DEPTH);
  p_irq_masked_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (ien == 5'd0) |-> !irq);
endmodule

// File: tb/test_spi_cmd_master.sv
`timescale 1ns/1ps
module test_spi_cmd_master;
  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 0, reg_rd = 0;
  logic [5:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic irq, sclk, cs_o, mosi, miso;

  always #10 clk = ~clk;

  spi_cmd_master i_spi_cmd_master (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq(irq), .sclk(sclk), .cs_o(cs_o), .mosi(mosi), .miso(miso));

  int n_run = 0, n_fail = 0;
  int cyc = 0, last_rise = 0, period = 0, ncap = 0, pidx = 0;
  logic [63:0] cap = 0;
  logic tb_cpol = 0, tb_trail = 0, sclk_q = 0, miso_pat = 0;
  logic [1:0] msrc = 0;
  logic [7:0] pat = 8'hA5;

  assign miso = (msrc == 2'd0) ? mosi : (msrc == 2'd1) ? 1'b1 : miso_pat;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (sclk !== sclk_q) begin
      if ((sclk != tb_cpol) != tb_trail) begin
        cap = {cap[62:0], mosi};
        ncap = ncap + 1;
      end
      if (sclk) begin
        period = cyc - last_rise;
        last_rise = cyc;
      end
      if (sclk != tb_cpol && msrc == 2'd2 && pidx < 8) begin
        miso_pat = pat[7 - pidx];
        pidx = pidx + 1;
      end
    end
    sclk_q = sclk;
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_rd = 1; #1 d = reg_rdata;
    @(negedge clk); reg_rd = 0;
  endtask

  task automatic clr_cap();
    cap = 0; ncap = 0; pidx = 0; miso_pat = 0;
  endtask

  task automatic wait_done();
    logic [31:0] s;
    for (int i = 0; i < 4000; i++) begin
      rd(6'h0C, s);
      if (s[1]) break;
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic run(input logic [31:0] cmd);
    wr(6'h0C, 32'h3E);
    clr_cap();
    wr(6'h08, cmd);
    wait_done();
  endtask

  task automatic drain();
    logic [31:0] c, d;
    for (int i = 0; i < 16; i++) begin
      rd(6'h18, c);
      if (c[3:0] == 0) break;
      rd(6'h20, d);
    end
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(6'h00, d); chk("R1 cfg", d, 0);
    rd(6'h04, d); chk("R1 div", d, 4);
    rd(6'h0C, d); chk("R1 status", d, 32'h04);
    rd(6'h18, d); chk("R1 count", d, 0);
    chk("R1 pins", {sclk, cs_o, mosi, irq}, 4'b0000);
  endtask

  task automatic t_regs();
    logic [31:0] d;
    wr(6'h00, 32'hFFFF_FFFF); rd(6'h00, d); chk("R2 cfg", d, 32'hC37);
    wr(6'h04, 32'h1234);      rd(6'h04, d); chk("R2 div", d, 32'h1234);
    wr(6'h10, 32'h1F);        rd(6'h10, d); chk("R2 ien", d, 32'h1F);
    wr(6'h14, 32'h5A);        rd(6'h14, d); chk("R2 thr", d, 32'h5A);
    wr(6'h10, 0); wr(6'h14, 0); wr(6'h04, 4); wr(6'h00, 32'h30);
  endtask

  task automatic t_period();
    wr(6'h04, 6); wr(6'h1C, 32'h55);
    run(32'h0007_0001);
    chk("R3 period div6", period, 6);
    wr(6'h04, 2); wr(6'h1C, 32'h55);
    run(32'h0007_0001);
    chk("R3 period clamped", period, 4);
    wr(6'h04, 4);
    tb_cpol = 1; wr(6'h00, 32'h32);
    chk("R3 idle cpol", sclk, 1);
    tb_cpol = 0; wr(6'h00, 32'h30);
  endtask

  task automatic t_msb();
    logic [31:0] d;
    wr(6'h1C, 32'h00A1_B2C3);
    wr(6'h0C, 32'h3E); clr_cap();
    wr(6'h08, 32'h0017_0003);
    rd(6'h0C, d); chk("R8 pending", d[0], 1);
    wait_done();
    chk("R5 mosi bits", cap[23:0], 24'hA1B2C3);
    chk("R4 bit count", ncap, 24);
    rd(6'h20, d); chk("R5 rx word", d, 32'h00A1B2C3);
    rd(6'h0C, d); chk("R8 done", d[1:0], 2'b10);
    wr(6'h0C, 32'h02); rd(6'h0C, d); chk("R8 done cleared", d[1], 0);
    clr_cap(); wr(6'h08, 32'h0007_0000);
    repeat (40) @(negedge clk);
    rd(6'h0C, d); chk("R4 idle command", {d[0], 32'(ncap)}, 0);
  endtask

  task automatic t_multi();
    logic [31:0] d;
    wr(6'h1C, 32'h1122_3344); wr(6'h1C, 32'h0000_00AB);
    run(32'h0027_0003);
    chk("R5 two words", cap[39:0], 40'h11223344AB);
    rd(6'h20, d); chk("R5 rx first", d, 32'h11223344);
    rd(6'h20, d); chk("R5 rx partial", d, 32'h000000AB);
  endtask

  task automatic t_lsb();
    logic [31:0] d;
    wr(6'h00, 32'h430); wr(6'h1C, 32'hC5);
    run(32'h0007_0003);
    chk("R5 lsb wire", cap[7:0], 8'hA3);
    rd(6'h20, d); chk("R5 lsb rx", d, 32'hC5);
    wr(6'h00, 32'h30);
  endtask

  task automatic t_cpha();
    logic [31:0] d;
    tb_trail = 1;
    wr(6'h00, 32'h31); wr(6'h1C, 32'h5A3C);
    run(32'h000F_0003);
    chk("R6 cpha1 wire", cap[15:0], 16'h5A3C);
    rd(6'h20, d); chk("R6 cpha1 rx", d, 32'h5A3C);
    tb_cpol = 1; wr(6'h00, 32'h33); wr(6'h1C, 32'h96);
    run(32'h0007_0003);
    chk("R6 cpol1 cpha1 wire", cap[7:0], 8'h96);
    rd(6'h20, d); chk("R6 cpol1 cpha1 rx", d, 32'h96);
    tb_trail = 0; tb_cpol = 0; wr(6'h00, 32'h30);
  endtask

  task automatic t_cs();
    wr(6'h00, 32'h34);
    chk("R7 idle active-low", cs_o, 1);
    wr(6'h1C, 32'h11); wr(6'h0C, 32'h3E);
    wr(6'h08, 32'h0007_0011);
    chk("R7 asserted", cs_o, 0);
    wait_done();
    chk("R7 held by continue", cs_o, 0);
    wr(6'h1C, 32'h22);
    run(32'h0007_0001);
    chk("R7 released", cs_o, 1);
    wr(6'h00, 32'h30);
  endtask

  task automatic t_busy();
    logic [31:0] d;
    wr(6'h1C, 32'hBEEF); wr(6'h0C, 32'h3E); clr_cap();
    wr(6'h08, 32'h000F_0001);
    repeat (6) @(negedge clk);
    wr(6'h08, 32'h0007_0001);
    wait_done();
    repeat (60) @(negedge clk);
    rd(6'h0C, d);
    chk("R9 ignored command", {d[0], 32'(ncap)}, {1'b0, 32'd16});
    chk("R9 data intact", cap[15:0], 16'hBEEF);
  endtask

  task automatic t_uf();
    logic [31:0] d;
    wr(6'h1C, 32'hFFFF_FFFF);
    run(32'h0027_0001);
    chk("R10 zero fill", cap[39:0], 40'hFFFFFFFF00);
    rd(6'h0C, d); chk("R10 underflow flag", d[4], 1);
  endtask

  task automatic t_thr();
    logic [31:0] d;
    wr(6'h14, 32'h21);
    wr(6'h1C, 1); wr(6'h1C, 2); wr(6'h1C, 3);
    wr(6'h0C, 32'h04); rd(6'h0C, d); chk("R12 tx above level", d[2], 0);
    run(32'h005F_0001);
    rd(6'h0C, d); chk("R12 tx at level", d[2], 1);
    msrc = 1;
    rd(6'h0C, d); chk("R12 rx empty", d[3], 0);
    run(32'h0007_0002);
    rd(6'h0C, d); chk("R12 rx final word", d[3], 1);
    rd(6'h18, d); chk("R12 rx count", d[3:0], 1);
    drain();
  endtask

  task automatic t_of();
    logic [31:0] d;
    run(32'h011F_0002);
    rd(6'h18, d); chk("R11 rx full", d[3:0], 8);
    rd(6'h0C, d); chk("R11 overflow and level", {d[5], d[3]}, 2'b11);
    rd(6'h20, d); chk("R11 kept word", d, 32'hFFFF_FFFF);
    drain();
    msrc = 0; wr(6'h14, 0);
  endtask

  task automatic t_irq();
    wr(6'h10, 32'h01); wr(6'h0C, 32'h3E);
    chk("R13 idle irq", irq, 0);
    wr(6'h1C, 32'h7);
    run(32'h0007_0001);
    chk("R13 done irq", irq, 1);
    wr(6'h0C, 32'h02);
    chk("R13 cleared irq", irq, 0);
    wr(6'h10, 32'h02);
    chk("R13 tx level irq", irq, 1);
    wr(6'h10, 0);
    chk("R13 masked irq", irq, 0);
  endtask

  task automatic t_late();
    logic [31:0] d;
    msrc = 2;
    run(32'h0007_0002);
    rd(6'h20, d); chk("R14 edge capture", d, 32'h52);
    wr(6'h00, 32'h830);
    run(32'h0007_0002);
    rd(6'h20, d); chk("R14 late capture", d, 32'hA5);
    wr(6'h00, 32'h30); msrc = 0;
  endtask

  initial begin
    #(200000 * 20);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_period();
    t_msb();
    t_multi();
    t_lsb();
    t_cpha();
    t_cs();
    t_busy();
    t_uf();
    t_thr();
    t_of();
    t_irq();
    t_late();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule